// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a write-back data cache for one requester. Its main store is a direct-mapped array of 256 lines of 16 bytes (4 KB). Next to it sits a small fully associative victim buffer that keeps lines recently pushed out of the main array. A request that misses in the main array probes the victim buffer first. On a victim hit the two lines trade places and lower memory is not touched. Only when both structures miss does the cache read the line from lower memory.

The requester side takes word reads and writes, one at a time, with a valid/ready handshake and a one-cycle response pulse. The lower-memory side moves whole lines. A request is held until the memory accepts it, and read data comes back later with a valid strobe. Dirty data reaches lower memory only when a dirty line drops out of the victim buffer.

Top module: `dmv_cache`

## Requirements
- R1: After reset, no line in the main array or the victim buffer is valid. The first access to any address is a miss that reads lower memory. While idle after reset, `cpu_req_ready` is 1 and neither `cpu_resp_valid` nor `mem_req_valid` is asserted.
- R2: A main-array hit needs a valid line whose stored tag equals the address tag. Its response appears one cycle after the request is accepted, with no lower-memory request.
- R3: Address bits [3:2] select the 32-bit word within the 16-byte line. Bits [11:4] select the main-array slot, which is the block address modulo 256. Bits [31:12] form the tag.
- R4: When the main array misses and the victim buffer holds the block, the response appears two cycles after acceptance and no lower-memory request is made. The victim line moves into the main slot and the displaced main line takes over its victim entry, keeping its dirty state.
- R5: When the main array misses and its slot holds a valid line, that line always goes into the victim buffer. The victim buffer compares the full block address (bits [31:4]) against every entry, and a block is held in at most one place.
- R6: On a miss in both structures, exactly one line read goes to lower memory, at the line-aligned address of the request. The response follows the return of the data. While a memory request waits for `mem_req_ready`, its address and direction hold steady.
- R7: The victim buffer replaces its entries in insertion order, oldest first. A swap on a victim hit does not change that order.
- R8: If the victim entry about to be overwritten is valid and dirty, the cache first writes it to lower memory with its own address and its latest data, and only then issues the line read.
- R9: A write updates only the cache and marks the line dirty, with no lower-memory write at that time. Every read returns the most recently written value of its word, whether the line sits in the main array, in the victim buffer, or in lower memory. A write's response returns the written word.
- R10: Only one request is outstanding. `cpu_req_ready` stays 0 from acceptance of a miss until its response, including while lower memory is busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req_valid | input | 1 | Requester presents an access |
| cpu_req_ready | output | 1 | Cache can accept an access this cycle |
| cpu_req_write | input | 1 | 1 = write word, 0 = read word |
| cpu_req_addr | input | 32 | Byte address of the access |
| cpu_req_wdata | input | 32 | Word to write |
| cpu_resp_valid | output | 1 | One-cycle pulse: access complete |
| cpu_resp_rdata | output | 32 | Read word, or the written word for writes |
| mem_req_valid | output | 1 | Line request to lower memory |
| mem_req_ready | input | 1 | Lower memory accepts the request |
| mem_req_write | output | 1 | 1 = line write-back, 0 = line read |
| mem_req_addr | output | 32 | Line-aligned byte address |
| mem_req_wdata | output | 128 | Line written back |
| mem_rvalid | input | 1 | Read line returned |
| mem_rdata | input | 128 | Returned line data |

## Verification
A main-array hit must answer in the cycle after the accepting edge, and a victim hit one cycle later. A double miss answers only after the memory returns data, so its timing is checked through the memory traffic and not through a fixed count. The bench drives each request before an edge, drops it after that edge, and counts falling edges until the response pulse is seen. It then compares the count against the latency class its own model predicts for the access. The memory responder counts line reads and writes per access, with their addresses and the written-back data. These are compared after the response against the reads and write-backs the model expects for the same access.

// File: rtl/dmv_cache_pkg.sv
package dmv_cache_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SWAP,
      ST_WB,
      ST_FILL_REQ,
      ST_FILL_WAIT
   } dmv_state_e;
endpackage

// File: rtl/dmv_main_array.sv
module dmv_main_array #(
   parameter int IDX_W  = 8,
   parameter int TAG_W  = 20,
   parameter int LINE_W = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic              rd_dirty,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [LINE_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic              wr_dirty,
   input  logic [LINE_W-1:0] wr_data
);
   localparam int SLOTS = 1 << IDX_W;

   logic [SLOTS-1:0]  valid_q;
   logic [SLOTS-1:0]  dirty_q;
   logic [TAG_W-1:0]  tag_q  [SLOTS];
   logic [LINE_W-1:0] data_q [SLOTS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         dirty_q[wr_idx] <= wr_dirty;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_dirty = dirty_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/dmv_victim_buf.sv
module dmv_victim_buf #(
   parameter int ENTRIES = 4,
   parameter int BA_W    = 28,
   parameter int LINE_W  = 128,
   localparam int PTR_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BA_W-1:0]   look_baddr,
   output logic [ENTRIES-1:0] hit_vec,
   output logic              hit,
   output logic [PTR_W-1:0]  hit_slot,
   output logic              hit_dirty,
   output logic [LINE_W-1:0] hit_data,
   output logic [PTR_W-1:0]  ptr,
   output logic              ptr_valid,
   output logic              ptr_dirty,
   output logic [BA_W-1:0]   ptr_baddr,
   output logic [LINE_W-1:0] ptr_data,
   input  logic              wr_en,
   input  logic [PTR_W-1:0]  wr_slot,
   input  logic              wr_valid,
   input  logic              wr_dirty,
   input  logic [BA_W-1:0]   wr_baddr,
   input  logic [LINE_W-1:0] wr_data,
   input  logic              advance
);
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] dirty_q;
   logic [BA_W-1:0]    baddr_q [ENTRIES];
   logic [LINE_W-1:0]  data_q  [ENTRIES];
   logic [PTR_W-1:0]   ptr_q;

   generate
      for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
         assign hit_vec[g] = valid_q[g] && (baddr_q[g] == look_baddr);
      end
   endgenerate

   always_comb begin
      hit_slot = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) hit_slot = PTR_W'(i);
      end
   end

   assign hit       = |hit_vec;
   assign hit_dirty = dirty_q[hit_slot];
   assign hit_data  = data_q[hit_slot];
   assign ptr       = ptr_q;
   assign ptr_valid = valid_q[ptr_q];
   assign ptr_dirty = dirty_q[ptr_q];
   assign ptr_baddr = baddr_q[ptr_q];
   assign ptr_data  = data_q[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
         ptr_q   <= '0;
      end else begin
         if (wr_en) begin
            valid_q[wr_slot] <= wr_valid;
            dirty_q[wr_slot] <= wr_dirty;
         end
         if (advance) ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         baddr_q[wr_slot] <= wr_baddr;
         data_q[wr_slot]  <= wr_data;
      end
   end
endmodule

// File: rtl/dmv_cache.sv
module dmv_cache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINE_BYTES = 16,
   parameter int NUM_LINES  = 256,
   parameter int VICTIM_N   = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req_valid,
   output logic                    cpu_req_ready,
   input  logic                    cpu_req_write,
   input  logic [ADDR_W-1:0]       cpu_req_addr,
   input  logic [WORD_W-1:0]       cpu_req_wdata,
   output logic                    cpu_resp_valid,
   output logic [WORD_W-1:0]       cpu_resp_rdata,
   output logic                    mem_req_valid,
   input  logic                    mem_req_ready,
   output logic                    mem_req_write,
   output logic [ADDR_W-1:0]       mem_req_addr,
   output logic [LINE_BYTES*8-1:0] mem_req_wdata,
   input  logic                    mem_rvalid,
   input  logic [LINE_BYTES*8-1:0] mem_rdata
);
   import dmv_cache_pkg::*;

   localparam int LINE_W = LINE_BYTES * 8;
   localparam int OFF_W  = $clog2(LINE_BYTES);
   localparam int IDX_W  = $clog2(NUM_LINES);
   localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
   localparam int BA_W   = ADDR_W - OFF_W;
   localparam int WPL    = LINE_W / WORD_W;
   localparam int WSEL_W = $clog2(WPL);
   localparam int BSEL_W = $clog2(WORD_W / 8);
   localparam int PTR_W  = $clog2(VICTIM_N);

   generate
      if ((1 << OFF_W) != LINE_BYTES || (1 << IDX_W) != NUM_LINES) begin : g_bad_pow2
         $error("line size and line count must be powers of two");
      end
      if (WPL < 2 || (WPL * WORD_W) != LINE_W) begin : g_bad_word
         $error("a line must hold at least two whole words");
      end
      if (VICTIM_N < 2 || (1 << PTR_W) != VICTIM_N) begin : g_bad_victim
         $error("victim entry count must be a power of two of at least 2");
      end
   endgenerate

   dmv_state_e state_q, state_d;
   logic [ADDR_W-1:0] r_addr;
   logic              r_write;
   logic [WORD_W-1:0] r_wdata;

   logic              accept;
   logic [ADDR_W-1:0] lk_addr;
   logic [IDX_W-1:0]  lk_idx;
   logic [TAG_W-1:0]  lk_tag;
   logic [BA_W-1:0]   lk_baddr;
   logic [WSEL_W-1:0] acc_wsel;
   logic              acc_write;
   logic [WORD_W-1:0] acc_wdata;

   logic              m_valid, m_dirty, main_hit;
   logic [TAG_W-1:0]  m_tag;
   logic [LINE_W-1:0] m_data;
   logic              m_we, m_wdirty;
   logic [LINE_W-1:0] base_line, new_line;

   logic [VICTIM_N-1:0] vb_hit_vec;
   logic              vb_hit, vb_hit_dirty;
   logic [PTR_W-1:0]  vb_hit_slot, vb_ptr;
   logic [LINE_W-1:0] vb_hit_data, vb_ptr_data;
   logic              vb_ptr_valid, vb_ptr_dirty;
   logic [BA_W-1:0]   vb_ptr_baddr;
   logic              v_we, v_adv;
   logic [PTR_W-1:0]  v_slot;
   logic              resp_now;

   assign cpu_req_ready = (state_q == ST_IDLE);
   assign accept        = cpu_req_valid && cpu_req_ready;
   assign lk_addr       = (state_q == ST_IDLE) ? cpu_req_addr : r_addr;
   assign lk_idx        = lk_addr[OFF_W +: IDX_W];
   assign lk_tag        = lk_addr[ADDR_W-1 -: TAG_W];
   assign lk_baddr      = lk_addr[ADDR_W-1 -: BA_W];
   assign acc_wsel      = lk_addr[BSEL_W +: WSEL_W];
   assign acc_write     = (state_q == ST_IDLE) ? cpu_req_write : r_write;
   assign acc_wdata     = (state_q == ST_IDLE) ? cpu_req_wdata : r_wdata;
   assign main_hit      = m_valid && (m_tag == lk_tag);

   dmv_main_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
      .clk(clk), .rst_n(rst_n), .rd_idx(lk_idx),
      .rd_valid(m_valid), .rd_dirty(m_dirty), .rd_tag(m_tag), .rd_data(m_data),
      .wr_en(m_we), .wr_idx(lk_idx), .wr_tag(lk_tag), .wr_dirty(m_wdirty), .wr_data(new_line)
   );

   dmv_victim_buf #(.ENTRIES(VICTIM_N), .BA_W(BA_W), .LINE_W(LINE_W)) u_victim (
      .clk(clk), .rst_n(rst_n), .look_baddr(lk_baddr),
      .hit_vec(vb_hit_vec), .hit(vb_hit), .hit_slot(vb_hit_slot),
      .hit_dirty(vb_hit_dirty), .hit_data(vb_hit_data),
      .ptr(vb_ptr), .ptr_valid(vb_ptr_valid), .ptr_dirty(vb_ptr_dirty),
      .ptr_baddr(vb_ptr_baddr), .ptr_data(vb_ptr_data),
      .wr_en(v_we), .wr_slot(v_slot), .wr_valid(m_valid), .wr_dirty(m_dirty),
      .wr_baddr({m_tag, lk_idx}), .wr_data(m_data), .advance(v_adv)
   );

   always_comb begin
      base_line = m_data;
      m_wdirty  = 1'b1;
      m_we      = 1'b0;
      v_we      = 1'b0;
      v_adv     = 1'b0;
      v_slot    = vb_hit_slot;
      resp_now  = 1'b0;
      state_d   = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept && main_hit) begin
               m_we     = cpu_req_write;
               resp_now = 1'b1;
            end else if (accept) begin
               if (vb_hit)                                  state_d = ST_SWAP;
               else if (m_valid && vb_ptr_valid && vb_ptr_dirty) state_d = ST_WB;
               else                                          state_d = ST_FILL_REQ;
            end
         end
         ST_SWAP: begin
            base_line = vb_hit_data;
            m_wdirty  = vb_hit_dirty | r_write;
            m_we      = 1'b1;
            v_we      = 1'b1;
            resp_now  = 1'b1;
            state_d   = ST_IDLE;
         end
         ST_WB: if (mem_req_ready) state_d = ST_FILL_REQ;
         ST_FILL_REQ: if (mem_req_ready) state_d = ST_FILL_WAIT;
         ST_FILL_WAIT: begin
            base_line = mem_rdata;
            m_wdirty  = r_write;
            v_slot    = vb_ptr;
            if (mem_rvalid) begin
               m_we     = 1'b1;
               v_we     = m_valid;
               v_adv    = m_valid;
               resp_now = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
      new_line = base_line;
      if (acc_write) new_line[acc_wsel*WORD_W +: WORD_W] = acc_wdata;
   end

   assign mem_req_valid = (state_q == ST_WB) || (state_q == ST_FILL_REQ);
   assign mem_req_write = (state_q == ST_WB);
   assign mem_req_addr  = (state_q == ST_WB) ? {vb_ptr_baddr, {OFF_W{1'b0}}}
                                             : {r_addr[ADDR_W-1 -: BA_W], {OFF_W{1'b0}}};
   assign mem_req_wdata = vb_ptr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q        <= ST_IDLE;
         r_addr         <= '0;
         r_write        <= 1'b0;
         r_wdata        <= '0;
         cpu_resp_valid <= 1'b0;
         cpu_resp_rdata <= '0;
      end else begin
         state_q        <= state_d;
         cpu_resp_valid <= resp_now;
         if (accept) begin
            r_addr  <= cpu_req_addr;
            r_write <= cpu_req_write;
            r_wdata <= cpu_req_wdata;
         end
         if (resp_now) begin
            cpu_resp_rdata <= acc_write ? acc_wdata : base_line[acc_wsel*WORD_W +: WORD_W];
         end
      end
   end
endmodule

// File: rtl/dmv_cache_checker.sv
module dmv_cache_checker #(
   parameter int ADDR_W   = 32,
   parameter int VICTIM_N = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cpu_req_valid,
   input logic                cpu_req_ready,
   input logic                cpu_resp_valid,
   input logic                mem_req_valid,
   input logic                mem_req_ready,
   input logic                mem_req_write,
   input logic [ADDR_W-1:0]   mem_req_addr,
   input logic                main_hit,
   input logic                vb_hit,
   input logic [VICTIM_N-1:0] vb_hit_vec
);
   logic acc;
   assign acc = cpu_req_valid && cpu_req_ready;

   assert_hit_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && main_hit |=> cpu_resp_valid);

   assert_victim_two_cycles_R4: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !main_hit && vb_hit |=> (!cpu_resp_valid && !mem_req_valid) ##1 cpu_resp_valid);

   assert_single_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vb_hit_vec));

   assert_mem_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=>
         mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

   assert_wb_then_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_write && mem_req_ready |=> mem_req_valid && !mem_req_write);

   assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !cpu_req_ready);
endmodule

bind dmv_cache dmv_cache_checker #(.ADDR_W(ADDR_W), .VICTIM_N(VICTIM_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
   .cpu_resp_valid(cpu_resp_valid), .mem_req_valid(mem_req_valid),
   .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
   .mem_req_addr(mem_req_addr), .main_hit(main_hit), .vb_hit(vb_hit),
   .vb_hit_vec(vb_hit_vec)
);

// File: tb/dmv_cache_test.sv
module dmv_cache_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_req_valid = 1'b0, cpu_req_ready, cpu_req_write = 1'b0;
   logic [31:0] cpu_req_addr = '0, cpu_req_wdata = '0;
   logic cpu_resp_valid;
   logic [31:0] cpu_resp_rdata;
   logic mem_req_valid, mem_req_ready = 1'b1, mem_req_write;
   logic [31:0] mem_req_addr;
   logic [127:0] mem_req_wdata;
   logic mem_rvalid = 1'b0;
   logic [127:0] mem_rdata = '0;

   always #5 clk = ~clk;

   dmv_cache uut (.*);

   int n_checks = 0, n_fail = 0;
   logic [31:0]  gold   [logic [31:0]];
   logic [127:0] mstore [logic [31:0]];
   int rd_cnt, wr_cnt;
   logic [31:0] rd_addr, wr_addr;
   logic [127:0] wr_data;
   bit pend = 0;
   int dly = 0;
   logic [31:0] pend_addr;

   bit          mv [256];
   bit          md [256];
   logic [19:0] mt [256];
   bit          vv [4];
   bit          vd [4];
   logic [27:0] vb [4];
   int          vp = 0;

   function automatic logic [31:0] init_word(logic [31:0] w);
      return {w[15:0], ~w[15:0]} ^ 32'h3C5A_0000;
   endfunction
   function automatic logic [31:0] gold_word(logic [31:0] a);
      logic [31:0] w = {a[31:2], 2'b00};
      return gold.exists(w) ? gold[w] : init_word(w);
   endfunction
   function automatic logic [127:0] gold_line(logic [27:0] ba);
      logic [127:0] l;
      for (int k = 0; k < 4; k++) l[k*32 +: 32] = gold_word({ba, 2'(k), 2'b00});
      return l;
   endfunction
   function automatic logic [127:0] mem_line(logic [31:0] a);
      logic [127:0] l;
      if (mstore.exists(a)) return mstore[a];
      for (int k = 0; k < 4; k++) l[k*32 +: 32] = init_word({a[31:4], 2'(k), 2'b00});
      return l;
   endfunction

   task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // lower-memory responder
   always @(negedge clk) mem_req_ready <= ($urandom % 4) != 0;
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
         if (mem_req_write) begin
            wr_cnt++; wr_addr = mem_req_addr; wr_data = mem_req_wdata;
            mstore[mem_req_addr] = mem_req_wdata;
         end else begin
            rd_cnt++; rd_addr = mem_req_addr; pend_addr = mem_req_addr;
            pend = 1; dly = 1 + ($urandom % 3);
         end
      end else if (pend) begin
         if (dly == 0) begin
            mem_rvalid <= 1'b1; mem_rdata <= mem_line(pend_addr); pend = 0;
         end else dly--;
      end
   end

   task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd);
      int idx = int'(a[11:4]);
      logic [19:0] tg = a[31:12];
      logic [27:0] ba = a[31:4];
      int cls, slot = -1, lat;
      bit exp_wb, ov, od;
      logic [19:0] ot;
      logic [27:0] wb_ba;
      logic [127:0] wb_line = '0;
      logic [31:0] exp_rd;
      if (mv[idx] && mt[idx] == tg) cls = 0;
      else begin
         for (int s = 0; s < 4; s++) if (vv[s] && vb[s] == ba) slot = s;
         cls = (slot >= 0) ? 1 : 2;
      end
      exp_wb = (cls == 2) && mv[idx] && vv[vp] && vd[vp];
      wb_ba  = vb[vp];
      if (exp_wb) wb_line = gold_line(wb_ba);
      exp_rd = wr ? wd : gold_word(a);
      if (wr) gold[{a[31:2], 2'b00}] = wd;
      ov = mv[idx]; ot = mt[idx]; od = md[idx];
      if (cls == 0) begin
         if (wr) md[idx] = 1;
      end else if (cls == 1) begin
         mv[idx] = 1; mt[idx] = tg; md[idx] = vd[slot] | wr;
         vv[slot] = ov; vb[slot] = {ot, 8'(idx)}; vd[slot] = od;
      end else begin
         if (ov) begin
            vv[vp] = 1; vb[vp] = {ot, 8'(idx)}; vd[vp] = od; vp = (vp + 1) % 4;
         end
         mv[idx] = 1; mt[idx] = tg; md[idx] = wr;
      end
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0;
      cpu_req_valid = 1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      cpu_req_valid = 0;
      lat = 1;
      if (cls == 2) chk(cpu_req_ready == 0, "R10 busy during miss", 128'(cpu_req_ready), 0);
      while (!cpu_resp_valid && lat < 400) begin @(negedge clk); lat++; end
      chk(cpu_resp_valid && cpu_resp_rdata == exp_rd, "R3 R9 response word",
          128'(cpu_resp_rdata), 128'(exp_rd));
      if (cls == 0) begin
         chk(lat == 1 && rd_cnt == 0 && wr_cnt == 0, "R2 main hit latency/traffic",
             128'(lat*100 + rd_cnt*10 + wr_cnt), 128'(100));
      end else if (cls == 1) begin
         chk(lat == 2 && rd_cnt == 0 && wr_cnt == 0, "R4 R5 R7 victim hit latency/traffic",
             128'(lat*100 + rd_cnt*10 + wr_cnt), 128'(200));
      end else begin
         chk(rd_cnt == 1 && rd_addr == {a[31:4], 4'h0}, "R1 R6 line read on double miss",
             128'({rd_cnt[3:0], rd_addr}), 128'({4'd1, a[31:4], 4'h0}));
         chk(wr_cnt == (exp_wb ? 1 : 0), "R8 write-back count", 128'(wr_cnt), 128'(exp_wb));
         if (exp_wb) chk(wr_addr == {wb_ba, 4'h0} && wr_data == wb_line,
                         "R8 write-back address/data", wr_data, wb_line);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) begin mv[i] = 0; md[i] = 0; mt[i] = '0; end
      for (int s = 0; s < 4; s++) begin vv[s] = 0; vd[s] = 0; vb[s] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      @(negedge clk);
      chk(cpu_req_ready == 1, "R1 ready after reset", 128'(cpu_req_ready), 1);
      chk(cpu_resp_valid == 0, "R1 no response after reset", 128'(cpu_resp_valid), 0);
      chk(mem_req_valid == 0, "R1 no memory request after reset", 128'(mem_req_valid), 0);
      // directed: miss, hit, write hit, conflict into victim, swaps back
      access(0, 32'h0000_1014, 0);
      access(0, 32'h0000_1018, 0);
      access(1, 32'h0000_1014, 32'hDEAD_0001);
      access(0, 32'h0000_2010, 0);
      access(0, 32'h0000_1014, 0);
      access(0, 32'h0000_2010, 0);
      // R3: top and bottom slots are separate
      access(1, 32'h0000_0FFC, 32'h1234_5678);
      access(1, 32'h0000_0000, 32'h8765_4321);
      access(0, 32'h0000_0FFC, 0);
      // R7 R8: stream of dirty conflicting lines fills then drains the victim buffer
      for (int t = 3; t < 11; t++) access(1, {20'(t), 8'h01, 4'h8}, 32'hA000_0000 + t);
      for (int t = 3; t < 11; t++) access(0, {20'(t), 8'h01, 4'h8}, 0);
      access(0, 32'h0000_1014, 0);
      // constrained random mix
      for (int n = 0; n < 1500; n++) begin
         logic [7:0] ix;
         case ($urandom % 4)
            0: ix = 8'h00; 1: ix = 8'h01; 2: ix = 8'h02; default: ix = 8'hFF;
         endcase
         access(1'($urandom % 2), {20'hA0000 | 20'($urandom % 6), ix, 2'($urandom % 4), 2'b00},
                $urandom);
      end
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule